// File: doc/BRIEF.md
# Time-of-Day Synchronisation Control Unit

This unit sits on each chip next to the time-of-day counter. It tracks whether the local time-of-day value can be trusted. Software reaches it through a 64-bit register port that accepts only whole, aligned 8-byte accesses. Register index is the byte address shifted right by three, and bit numbers below count from the most significant bit, so bit n is data bit 63-n. Software writes command registers to declare the value invalid, load it, or start it. Software can also emit synchronisation triggers toward the peer chips. Triggers that peers send arrive on a separate input and move the state machine directly, without passing through the register port.

The state machine has four states, with fixed encodings: ERROR (0), STOPPED (1), RUNNING (2) and NOT_SET (7). Its transitions are:
- "arm" takes any state to NOT_SET. It fires on a load-mod write carrying the enable key, or on a received invalidate trigger.
- "load-run" takes NOT_SET to RUNNING.
- "load-hold" takes NOT_SET to STOPPED.
- "start" takes STOPPED to RUNNING.
- "peer-send" takes NOT_SET to RUNNING.

A command that is illegal in the current state is dropped. So is an access the unit does not implement. In both cases the fault is recorded in a sticky error register and a one-cycle protocol-error pulse is raised. Reads return their data one cycle after the access. The data reflects the state as it was in the access cycle.

Top module: `tod_sync_ctrl`

## Requirements
- R1: After reset the state is ERROR (0), the error register reads zero, and rd_valid, proto_err and trig_out_valid are low.
- R2: An access whose size is not 8 or whose byte address has nonzero low three bits has no effect. It returns no read data, sets error bit 3 and pulses proto_err.
- R3: A write to index 0x18 with data bit 0 set (data[63]) moves any state to NOT_SET. With bit 0 clear the write is dropped and sets error bit 1.
- R4: A write to index 0x21 in NOT_SET moves to STOPPED if data bit 63 (data[0]) is 1, and to RUNNING if it is 0. In any other state the write is dropped and sets error bit 0.
- R5: A write to index 0x22 in STOPPED moves to RUNNING. In any other state the write is dropped and sets error bit 0.
- R6: A received trigger of type 5 forces NOT_SET from any state. Type 4 moves NOT_SET to RUNNING and is silently ignored in any other state. Any other type changes nothing and sets error bit 4.
- R7: When a peer trigger and a command write (index 0x18, 0x21 or 0x22) arrive in the same cycle, the trigger acts, the command is dropped, and error bit 5 is set.
- R8: Writes to index 0x15 or 0x16 pulse trig_out_valid one cycle later, with trig_out_type 4 or 5 respectively. The unit's own state does not change.
- R9: A read of index 0x08 returns bits 6 to 10, 12, 21 and 26 set. Bit 20 is set when RUNNING. Exactly one of bits 23/24/25 is set: 23 when cfg_primary, else 24 when cfg_secondary, else 25.
- R10: A read of index 0x24 returns only bit 4, set when RUNNING. A read of index 0x27 returns zero without error.
- R11: A write to index 0x07 keeps data bits 0 to 31 only. Bit 1 is forced to cfg_primary and bit 2 to 1. Reset loads the same forced pattern, and bits 32 to 63 read zero.
- R12: Index 0x30 reads the error bits (0 to 5). Writing a 1 clears the matching bit. A fault in the same cycle sets its bit regardless of the clear.
- R13: An unimplemented index sets error bit 2 and pulses proto_err. On a read it returns zero data.
- R14: Read data appears with rd_valid exactly one cycle after the access. proto_err and trig_out_valid are likewise registered one cycle after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_primary | input | 1 | Static: this unit is the primary master |
| cfg_secondary | input | 1 | Static: this unit is the backup master |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address; index = addr >> 3 |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data |
| peer_trig_valid | input | 1 | One-cycle pulse: trigger received from a peer |
| peer_trig_type | input | 3 | Received trigger type |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| trig_out_valid | output | 1 | One-cycle pulse: trigger to broadcast to peers |
| trig_out_type | output | 3 | Type of the emitted trigger |
| proto_err | output | 1 | One-cycle pulse on any dropped or faulty operation |
| tod_state | output | 3 | Current state encoding |

## Verification
Two functions can meet in one cycle: a received peer trigger and a software command write. The bench provokes this by driving peer_trig_valid together with load, start and load-mod writes, in several states. It judges the outcome against a behavioural model, which applies the trigger, discards the command and sets error bit 5. The bench also collides a fault with an error-register clear in one cycle, and checks that the set wins.

// File: rtl/tod_sync_pkg.sv
package tod_sync_pkg;

    localparam int DW     = 64;
    localparam int TRIG_W = 3;
    localparam int CTRL_W = 32;
    localparam int ERR_N  = 6;

    // register indices (byte address >> 3)
    localparam int IDX_CTRL       = 'h07;
    localparam int IDX_STATUS     = 'h08;
    localparam int IDX_EMIT_SEND  = 'h15;
    localparam int IDX_EMIT_INVAL = 'h16;
    localparam int IDX_LOAD_MOD   = 'h18;
    localparam int IDX_LOAD       = 'h21;
    localparam int IDX_START      = 'h22;
    localparam int IDX_FSM        = 'h24;
    localparam int IDX_TXCTL      = 'h27;
    localparam int IDX_ERR        = 'h30;

    localparam logic [TRIG_W-1:0] TRIG_SEND  = 3'd4;
    localparam logic [TRIG_W-1:0] TRIG_INVAL = 3'd5;

    // error bit numbers, most-significant-first
    localparam int ERR_STATE   = 0;
    localparam int ERR_KEY     = 1;
    localparam int ERR_UNIMPL  = 2;
    localparam int ERR_ACCESS  = 3;
    localparam int ERR_PEER    = 4;
    localparam int ERR_PREEMPT = 5;

    typedef enum logic [2:0] {
        ST_ERROR   = 3'd0,
        ST_STOPPED = 3'd1,
        ST_RUNNING = 3'd2,
        ST_NOT_SET = 3'd7
    } tod_state_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_err;
        logic ld_mod;
        logic ld_val;
        logic start;
        logic emit_send;
        logic emit_inval;
        logic rd_any;
        logic rd_ctrl;
        logic rd_status;
        logic rd_err;
        logic rd_fsm;
        logic bad_access;
        logic unimpl;
    } tod_acc_t;

    typedef struct packed {
        logic rej_state;
        logic bad_key;
        logic bad_peer;
        logic preempt;
    } tod_flag_t;

    function automatic logic [DW-1:0] status_word(input logic running,
                                                  input logic primary,
                                                  input logic secondary);
        logic [DW-1:0] w;
        w = '0;
        for (int n = 6; n <= 10; n++) w[DW-1-n] = 1'b1;
        w[DW-1-12] = 1'b1;
        w[DW-1-21] = 1'b1;
        w[DW-1-26] = 1'b1;
        w[DW-1-20] = running;
        if (primary)        w[DW-1-23] = 1'b1;
        else if (secondary) w[DW-1-24] = 1'b1;
        else                w[DW-1-25] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/tod_acc_decode.sv
module tod_acc_decode
    import tod_sync_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output tod_acc_t          acc
);

    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0] idx;
    logic             well_formed;

    assign idx         = addr[ADDR_W-1:3];
    assign well_formed = (size == 4'd8) && (addr[2:0] == 3'b000);

    always_comb begin
        acc = '0;
        if (valid) begin
            if (!well_formed) begin
                acc.bad_access = 1'b1;
            end else if (write) begin
                case (idx)
                    IDX_W'(IDX_CTRL):       acc.wr_ctrl    = 1'b1;
                    IDX_W'(IDX_ERR):        acc.wr_err     = 1'b1;
                    IDX_W'(IDX_LOAD_MOD):   acc.ld_mod     = 1'b1;
                    IDX_W'(IDX_LOAD):       acc.ld_val     = 1'b1;
                    IDX_W'(IDX_START):      acc.start      = 1'b1;
                    IDX_W'(IDX_EMIT_SEND):  acc.emit_send  = 1'b1;
                    IDX_W'(IDX_EMIT_INVAL): acc.emit_inval = 1'b1;
                    default:                acc.unimpl     = 1'b1;
                endcase
            end else begin
                acc.rd_any = 1'b1;
                case (idx)
                    IDX_W'(IDX_CTRL):   acc.rd_ctrl   = 1'b1;
                    IDX_W'(IDX_STATUS): acc.rd_status = 1'b1;
                    IDX_W'(IDX_ERR):    acc.rd_err    = 1'b1;
                    IDX_W'(IDX_FSM):    acc.rd_fsm    = 1'b1;
                    IDX_W'(IDX_TXCTL):  ;
                    default:            acc.unimpl    = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/tod_state_fsm.sv
module tod_state_fsm
    import tod_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tod_acc_t          acc,
    input  logic              key_bit,
    input  logic              hold_bit,
    input  logic              peer_valid,
    input  logic [TRIG_W-1:0] peer_type,
    output tod_state_e        state,
    output tod_flag_t         flags
);

    tod_state_e state_q, state_d;
    logic       cmd_write;

    assign cmd_write = acc.ld_mod | acc.ld_val | acc.start;

    always_comb begin
        state_d = state_q;
        flags   = '0;
        if (peer_valid) begin
            // received trigger wins over a command write
            flags.preempt = cmd_write;
            case (peer_type)
                TRIG_INVAL: state_d = ST_NOT_SET;
                TRIG_SEND:  if (state_q == ST_NOT_SET) state_d = ST_RUNNING;
                default:    flags.bad_peer = 1'b1;
            endcase
        end else if (acc.ld_mod) begin
            if (key_bit) state_d = ST_NOT_SET;
            else         flags.bad_key = 1'b1;
        end else if (acc.ld_val || acc.start) begin
            unique case (state_q)
                ST_NOT_SET: begin
                    if (acc.ld_val) state_d = hold_bit ? ST_STOPPED : ST_RUNNING;
                    else            flags.rej_state = 1'b1;
                end
                ST_STOPPED: begin
                    if (acc.start) state_d = ST_RUNNING;
                    else           flags.rej_state = 1'b1;
                end
                ST_ERROR, ST_RUNNING: flags.rej_state = 1'b1;
                default:              flags.rej_state = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ERROR;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/tod_csr_bank.sv
module tod_csr_bank
    import tod_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_primary,
    input  logic              cfg_secondary,
    input  tod_acc_t          acc,
    input  logic [CTRL_W-1:0] wdata_hi,
    input  tod_state_e        state,
    input  tod_flag_t         flags,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              proto_err,
    output logic              trig_valid,
    output logic [TRIG_W-1:0] trig_type
);

    logic [CTRL_W-1:0] ctrl_q, ctrl_wr, ctrl_rst;
    logic [ERR_N-1:0]  err_q, err_set, err_clr;
    logic [DW-1:0]     rd_mux;
    logic              running;

    assign running = (state == ST_RUNNING);

    always_comb begin
        ctrl_rst              = '0;
        ctrl_rst[CTRL_W-1-1]  = cfg_primary;
        ctrl_rst[CTRL_W-1-2]  = 1'b1;
        ctrl_wr               = wdata_hi;
        ctrl_wr[CTRL_W-1-1]   = cfg_primary;
        ctrl_wr[CTRL_W-1-2]   = 1'b1;
    end

    always_comb begin
        err_set = '0;
        err_set[ERR_N-1-ERR_STATE]   = flags.rej_state;
        err_set[ERR_N-1-ERR_KEY]     = flags.bad_key;
        err_set[ERR_N-1-ERR_UNIMPL]  = acc.unimpl;
        err_set[ERR_N-1-ERR_ACCESS]  = acc.bad_access;
        err_set[ERR_N-1-ERR_PEER]    = flags.bad_peer;
        err_set[ERR_N-1-ERR_PREEMPT] = flags.preempt;
        err_clr = acc.wr_err ? wdata_hi[CTRL_W-1 -: ERR_N] : '0;
    end

    always_comb begin
        rd_mux = '0;
        if (acc.rd_ctrl)        rd_mux = {ctrl_q, {(DW-CTRL_W){1'b0}}};
        else if (acc.rd_status) rd_mux = status_word(running, cfg_primary, cfg_secondary);
        else if (acc.rd_err)    rd_mux = {err_q, {(DW-ERR_N){1'b0}}};
        else if (acc.rd_fsm)    rd_mux[DW-1-4] = running;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= ctrl_rst;
            err_q      <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            proto_err  <= 1'b0;
            trig_valid <= 1'b0;
            trig_type  <= '0;
        end else begin
            if (acc.wr_ctrl) ctrl_q <= ctrl_wr;
            err_q      <= (err_q & ~err_clr) | err_set;
            rd_valid   <= acc.rd_any;
            rd_data    <= rd_mux;
            proto_err  <= |err_set;
            trig_valid <= acc.emit_send | acc.emit_inval;
            trig_type  <= acc.emit_send  ? TRIG_SEND :
                          acc.emit_inval ? TRIG_INVAL : '0;
        end
    end

endmodule

// File: rtl/tod_sync_ctrl.sv
module tod_sync_ctrl
    import tod_sync_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_primary,
    input  logic              cfg_secondary,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    input  logic              peer_trig_valid,
    input  logic [2:0]        peer_trig_type,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              trig_out_valid,
    output logic [2:0]        trig_out_type,
    output logic              proto_err,
    output logic [2:0]        tod_state
);

    tod_acc_t   acc;
    tod_flag_t  flags;
    tod_state_e state;
    logic       wdata_unused;

    assign wdata_unused = ^reg_wdata[DW-CTRL_W-1:1];

    tod_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (reg_valid),
        .write (reg_write),
        .addr  (reg_addr),
        .size  (reg_size),
        .acc   (acc)
    );

    tod_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .key_bit    (reg_wdata[DW-1]),
        .hold_bit   (reg_wdata[0]),
        .peer_valid (peer_trig_valid),
        .peer_type  (peer_trig_type),
        .state      (state),
        .flags      (flags)
    );

    tod_csr_bank u_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_primary   (cfg_primary),
        .cfg_secondary (cfg_secondary),
        .acc           (acc),
        .wdata_hi      (reg_wdata[DW-1 -: CTRL_W]),
        .state         (state),
        .flags         (flags),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .proto_err     (proto_err),
        .trig_valid    (trig_out_valid),
        .trig_type     (trig_out_type)
    );

    assign tod_state = state;

endmodule

// File: rtl/tod_sync_ctrl_chk.sv
module tod_sync_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_primary,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [3:0]        reg_size,
    input logic              peer_trig_valid,
    input logic [2:0]        peer_trig_type,
    input logic              rd_valid,
    input logic [1:0]        rd_ctl_bits,
    input logic [31:0]       rd_lo,
    input logic              trig_out_valid,
    input logic              proto_err,
    input logic [2:0]        tod_state
);

    logic ok_access;
    logic [ADDR_W-4:0] idx;

    assign ok_access = (reg_size == 4'd8) && (reg_addr[2:0] == 3'b000);
    assign idx       = reg_addr[ADDR_W-1:3];

    AST_ERROR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_state == 3'd0) |=> (tod_state == 3'd0 || tod_state == 3'd7)); // R3

    AST_STOPPED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_state == 3'd1) |=> (tod_state inside {3'd1, 3'd2, 3'd7})); // R5

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_state != 3'd2) |=> (tod_state != 3'd2 || $past(tod_state) inside {3'd1, 3'd7})); // R4

    AST_PEER_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_trig_valid && peer_trig_type == 3'd5) |=> (tod_state == 3'd7)); // R6

    AST_EMIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && ok_access && !peer_trig_valid &&
         (idx == (ADDR_W-3)'('h15) || idx == (ADDR_W-3)'('h16)))
        |=> ($stable(tod_state) && trig_out_valid)); // R8

    AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && ok_access && idx == (ADDR_W-3)'('h07))
        |=> (rd_valid && rd_ctl_bits == {cfg_primary, 1'b1} && rd_lo == 32'd0)); // R11

    AST_BAD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !ok_access) |=> (proto_err && !rd_valid && !trig_out_valid)); // R2

endmodule

bind tod_sync_ctrl tod_sync_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_primary     (cfg_primary),
    .reg_valid       (reg_valid),
    .reg_write       (reg_write),
    .reg_addr        (reg_addr),
    .reg_size        (reg_size),
    .peer_trig_valid (peer_trig_valid),
    .peer_trig_type  (peer_trig_type),
    .rd_valid        (rd_valid),
    .rd_ctl_bits     (rd_data[62:61]),
    .rd_lo           (rd_data[31:0]),
    .trig_out_valid  (trig_out_valid),
    .proto_err       (proto_err),
    .tod_state       (tod_state)
);

// File: tb/tod_sync_ctrl_tb.sv
module tod_sync_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_primary, cfg_secondary;
    logic        reg_valid, reg_write;
    logic [15:0] reg_addr;
    logic [3:0]  reg_size;
    logic [63:0] reg_wdata;
    logic        peer_trig_valid;
    logic [2:0]  peer_trig_type;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        trig_out_valid;
    logic [2:0]  trig_out_type;
    logic        proto_err;
    logic [2:0]  tod_state;

    int checks = 0;
    int fails  = 0;

    // behavioural reference model
    int          m_st;
    logic [63:0] m_ctrl;
    logic [63:0] m_err;
    bit          e_rdv, e_perr, e_tv;
    logic [63:0] e_rdd;
    int          e_tt;

    always #10 clk = ~clk;

    tod_sync_ctrl u_dut (.*);

    function automatic logic [63:0] mb(int n);
        return 64'h1 << (63 - n);
    endfunction

    function automatic logic [63:0] m_status();
        logic [63:0] d = 0;
        for (int n = 6; n <= 10; n++) d |= mb(n);
        d |= mb(12) | mb(21) | mb(26);
        if (m_st == 2) d |= mb(20);
        if (cfg_primary) d |= mb(23);
        else if (cfg_secondary) d |= mb(24);
        else d |= mb(25);
        return d;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "tod_state", 64'(tod_state), 64'(m_st));
        chk(tag, "rd_valid", 64'(rd_valid), 64'(e_rdv));
        if (e_rdv) chk(tag, "rd_data", rd_data, e_rdd);
        chk(tag, "proto_err", 64'(proto_err), 64'(e_perr));
        chk(tag, "trig_out_valid", 64'(trig_out_valid), 64'(e_tv));
        if (e_tv) chk(tag, "trig_out_type", 64'(trig_out_type), 64'(e_tt));
    endtask

    task automatic step(string tag, bit v, bit w, logic [15:0] a, logic [3:0] sz,
                        logic [63:0] d, bit pv, logic [2:0] pt);
        logic [63:0] set, clr;
        int ns, idx;
        bit cmd;
        reg_valid = v; reg_write = w; reg_addr = a; reg_size = sz; reg_wdata = d;
        peer_trig_valid = pv; peer_trig_type = pt;
        set = 0; clr = 0; ns = m_st; e_rdv = 0; e_rdd = 0; e_tv = 0; e_tt = 0;
        idx = int'(a) / 8;
        cmd = v && w && sz == 8 && a[2:0] == 0 && (idx == 'h18 || idx == 'h21 || idx == 'h22);
        if (pv) begin
            if (pt == 5) ns = 7;
            else if (pt == 4) begin if (m_st == 7) ns = 2; end
            else set |= mb(4);
            if (cmd) set |= mb(5);
        end
        if (v) begin
            if (sz != 8 || a[2:0] != 0) set |= mb(3);
            else if (w) begin
                case (idx)
                    'h07: begin m_ctrl = {d[63:32], 32'd0}; m_ctrl[62] = cfg_primary; m_ctrl[61] = 1'b1; end
                    'h30: clr = d & {6'h3f, 58'd0};
                    'h18: if (!pv) begin if (d[63]) ns = 7; else set |= mb(1); end
                    'h21: if (!pv) begin if (m_st == 7) ns = d[0] ? 1 : 2; else set |= mb(0); end
                    'h22: if (!pv) begin if (m_st == 1) ns = 2; else set |= mb(0); end
                    'h15: begin e_tv = 1; e_tt = 4; end
                    'h16: begin e_tv = 1; e_tt = 5; end
                    default: set |= mb(2);
                endcase
            end else begin
                e_rdv = 1;
                case (idx)
                    'h07: e_rdd = m_ctrl;
                    'h08: e_rdd = m_status();
                    'h30: e_rdd = m_err;
                    'h24: e_rdd = (m_st == 2) ? mb(4) : 64'd0;
                    'h27: e_rdd = 0;
                    default: set |= mb(2);
                endcase
            end
        end
        m_err  = (m_err & ~clr) | set;
        e_perr = (set != 0);
        m_st   = ns;
        @(posedge clk);
        @(negedge clk);
        reg_valid = 0; peer_trig_valid = 0;
        compare(tag);
    endtask

    task automatic wr(string tag, int idx, logic [63:0] d);
        step(tag, 1, 1, 16'(idx * 8), 8, d, 0, 0);
    endtask
    task automatic rd(string tag, int idx);
        step(tag, 1, 0, 16'(idx * 8), 8, 0, 0, 0);
    endtask
    task automatic peer(string tag, logic [2:0] t);
        step(tag, 0, 0, 0, 8, 0, 1, t);
    endtask

    task automatic do_reset(bit p, bit s);
        cfg_primary = p; cfg_secondary = s;
        rst_n = 0; reg_valid = 0; reg_write = 0; reg_addr = 0; reg_size = 8;
        reg_wdata = 0; peer_trig_valid = 0; peer_trig_type = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_st = 0; m_err = 0;
        m_ctrl = mb(2) | (p ? mb(1) : 64'd0);
        e_rdv = 0; e_perr = 0; e_tv = 0;
        compare("R1");
    endtask

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1, 0);
        rd("R1", 'h30);
        rd("R11", 'h07);
        rd("R9", 'h08);
        // illegal commands in ERROR
        wr("R4", 'h21, 0);
        wr("R5", 'h22, 0);
        wr("R3", 'h18, 64'h7fff_ffff_ffff_ffff);
        rd("R12", 'h30);
        // load-mod, load-hold, start
        wr("R3", 'h18, mb(0));
        wr("R4", 'h21, mb(63));
        rd("R10", 'h24);
        rd("R9", 'h08);
        wr("R4", 'h21, 0);
        wr("R5", 'h22, 0);
        rd("R10", 'h24);
        rd("R9", 'h08);
        wr("R5", 'h22, 0);
        // load-run from any state via load-mod
        wr("R3", 'h18, mb(0));
        wr("R4", 'h21, 0);
        rd("R14", 'h24);
        rd("R14", 'h08);
        // peer triggers
        peer("R6", 4);
        peer("R6", 5);
        peer("R6", 5);
        peer("R6", 4);
        peer("R6", 3);
        peer("R6", 0);
        // collisions between peer trigger and command
        step("R7", 1, 1, 16'h21 * 8, 8, 0, 1, 5);
        step("R7", 1, 1, 16'h22 * 8, 8, 0, 1, 4);
        step("R7", 1, 1, 16'h18 * 8, 8, mb(0), 1, 4);
        wr("R4", 'h21, mb(63));
        step("R7", 1, 1, 16'h22 * 8, 8, 0, 1, 4);
        rd("R7", 'h30);
        // emit triggers
        wr("R8", 'h15, 64'hffff_ffff_ffff_ffff);
        wr("R8", 'h16, 0);
        step("R8", 1, 1, 16'h16 * 8, 8, 0, 1, 4);
        rd("R8", 'h08);
        // bad access shapes
        step("R2", 1, 1, 16'h3a, 8, 64'hffff_ffff_ffff_ffff, 0, 0);
        step("R2", 1, 1, 16'h38, 4, 64'hffff_ffff_ffff_ffff, 0, 0);
        step("R2", 1, 0, 16'h41, 8, 0, 0, 0);
        rd("R2", 'h07);
        // unimplemented and zero registers
        rd("R13", 'h18);
        wr("R13", 'h99, 64'h1);
        rd("R10", 'h27);
        // control register
        wr("R11", 'h07, 64'hffff_ffff_ffff_ffff);
        rd("R11", 'h07);
        wr("R11", 'h07, 64'h0000_0000_ffff_ffff);
        rd("R11", 'h07);
        // error register clear and set-wins
        rd("R12", 'h30);
        wr("R12", 'h30, mb(0) | mb(2));
        rd("R12", 'h30);
        step("R12", 1, 1, 16'h30 * 8, 8, 64'hffff_ffff_ffff_ffff, 1, 6);
        rd("R12", 'h30);
        wr("R12", 'h30, 64'hffff_ffff_ffff_ffff);
        rd("R12", 'h30);
        // configuration variants
        do_reset(0, 1);
        rd("R9", 'h08);
        rd("R11", 'h07);
        wr("R11", 'h07, mb(1));
        rd("R11", 'h07);
        do_reset(0, 0);
        rd("R9", 'h08);
        peer("R6", 5);
        peer("R6", 4);
        rd("R9", 'h08);
        do_reset(1, 1);
        rd("R9", 'h08);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule